// File: doc/BRIEF.md
# Streaming Complex Product Joiner

This block forms the complex product of two valid/ready streams. Stream A carries data samples and stream B carries the unit sinusoid they are to be rotated by. The block pairs one beat of A with one beat of B, forms the full-precision product and drops a fixed number of low bits. The result goes out on a third stream. Each word holds the imaginary part in its upper half and the real part in its lower half.

The two inputs advance in lockstep, so an A beat and a B beat are always accepted in the same clock cycle. Neither input is taken unless the other one is also presenting a beat. Back-pressure on the output stalls the whole two-stage pipeline, and through it both inputs. The end-of-packet flag travels with the A beat. The flag on B is accepted and then discarded. Operand formats: A components are 21-bit signed with 15 fractional bits, each sign-extended into a 24-bit lane. B components are 16-bit signed with 14 fractional bits. The product keeps 32 bits per component with 23 fractional bits.

Top module: `cplx_stream_mult`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `y_valid` is low.
- R2: `a_ready` equals `b_valid && (!y_valid || y_ready)`, and `b_ready` equals `a_valid && (!y_valid || y_ready)`. A and B are therefore always accepted in the same cycle.
- R3: `y_data[31:0]` is the real part Ai·Bi − Aq·Bq. It is formed at 38-bit precision and then shifted right arithmetically by 6 bits.
- R4: `y_data[63:32]` is the imaginary part Ai·Bq + Aq·Bi. It is formed at 38-bit precision and then shifted right arithmetically by 6 bits.
- R5: A has Aq in bits [44:24] and Ai in bits [20:0], both signed. Bits [47:45] and [23:21] have no effect on the result.
- R6: B has Bq in bits [31:16] and Bi in bits [15:0], both signed.
- R7: `y_last` equals the `a_last` of the pair that produced the beat. `b_last` has no effect.
- R8: If `y_ready` stays high, a pair accepted at a clock edge appears on `y_valid` after the second following edge.
- R9: While `y_valid` is high and `y_ready` is low, `y_valid`, `y_data` and `y_last` hold their values.
- R10: Every accepted pair produces exactly one output beat, and the beats leave in the order the pairs were accepted.
- R11: The bit drop is a floor. A negative product with nonzero discarded bits moves toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_data | input | 48 | Sample stream: Q lane [47:24], I lane [23:0] |
| a_last | input | 1 | End of packet on the sample stream |
| a_valid | input | 1 | Sample beat present |
| a_ready | output | 1 | Sample beat taken this cycle |
| b_data | input | 32 | Sinusoid stream: Q [31:16], I [15:0] |
| b_last | input | 1 | End flag on the sinusoid stream (discarded) |
| b_valid | input | 1 | Sinusoid beat present |
| b_ready | output | 1 | Sinusoid beat taken this cycle |
| y_data | output | 64 | Product: Q [63:32], I [31:0] |
| y_last | output | 1 | End of packet, from the sample stream |
| y_valid | output | 1 | Product beat present |
| y_ready | input | 1 | Downstream accepts the product beat |

## Verification
The assertions assume the upstream follows ordinary stream rules. Once a beat is offered, it stays offered and unchanged until it is taken. Reset is held for at least one clock edge before any traffic. The stimulus holds each input word and valid until the handshake cycle, then chooses new data with random gaps. It also applies random output back-pressure. Directed vectors hit the most negative and most positive operands, junk in the lane padding bits, and negative products whose dropped bits are nonzero.

// File: rtl/cmj_pkg.sv
package cmj_pkg;
  // Default operand and result formats
  localparam int unsigned CMJ_A_W    = 21;  // sample component width
  localparam int unsigned CMJ_A_LANE = 24;  // sample lane width
  localparam int unsigned CMJ_B_W    = 16;  // sinusoid component width
  localparam int unsigned CMJ_DROP   = 6;   // low bits discarded

  // Which half of a packed word a lane occupies
  typedef enum logic {
    LANE_RE = 1'b0,
    LANE_IM = 1'b1
  } lane_e;
endpackage

// File: rtl/cmj_join.sv
module cmj_join (
  input  logic clk,
  input  logic rst,
  input  logic a_valid,
  input  logic b_valid,
  input  logic y_valid,
  input  logic y_ready,
  output logic a_ready,
  output logic b_ready,
  output logic adv,
  output logic fire
);
  // The pipeline may move when its last stage is empty or being drained
  assign adv     = !y_valid || y_ready;
  assign a_ready = b_valid && adv;
  assign b_ready = a_valid && adv;
  assign fire    = a_valid && b_valid && adv;

  // R2: one side is never taken without the other
  a_r2_lockstep: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready) |-> (b_valid && b_ready));
  // R9: nothing enters while the output is stalled
  a_r9_no_entry_on_stall: assert property (@(posedge clk) disable iff (rst)
    (y_valid && !y_ready) |-> (!a_ready && !b_ready));
endmodule

// File: rtl/cmj_unpack.sv
module cmj_unpack #(
  parameter int unsigned LANE_W = 24,
  parameter int unsigned COMP_W = 21
) (
  input  logic [2*LANE_W-1:0]      word,
  output logic signed [COMP_W-1:0] comp_re,
  output logic signed [COMP_W-1:0] comp_im
);
  import cmj_pkg::*;

  logic [COMP_W-1:0] comp [2];

  // One slice per lane; a lane's padding bits above COMP_W are dropped
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign comp[g] = word[g*LANE_W +: COMP_W];
  end

  assign comp_re = $signed(comp[int'(LANE_RE)]);
  assign comp_im = $signed(comp[int'(LANE_IM)]);

  if (LANE_W > COMP_W) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^{word[2*LANE_W-1 -: (LANE_W-COMP_W)],
                          word[LANE_W-1 -: (LANE_W-COMP_W)]};
  end
endmodule

// File: rtl/cmj_mult_core.sv
module cmj_mult_core #(
  parameter int unsigned A_W  = 21,
  parameter int unsigned B_W  = 16,
  parameter int unsigned DROP = 6,
  localparam int unsigned PROD_W = A_W + B_W + 1,
  localparam int unsigned OUT_W  = PROD_W - DROP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  fire,
  input  logic signed [A_W-1:0] a_re,
  input  logic signed [A_W-1:0] a_im,
  input  logic signed [B_W-1:0] b_re,
  input  logic signed [B_W-1:0] b_im,
  input  logic                  in_last,
  output logic                  out_valid,
  output logic [2*OUT_W-1:0]    out_data,
  output logic                  out_last
);
  // Operands widened to the full product width before multiplying
  logic signed [PROD_W-1:0] xa_re, xa_im, xb_re, xb_im;
  assign xa_re = PROD_W'(a_re);
  assign xa_im = PROD_W'(a_im);
  assign xb_re = PROD_W'(b_re);
  assign xb_im = PROD_W'(b_im);

  // Stage 1: four partial products
  logic signed [PROD_W-1:0] p_rr, p_ii, p_ri, p_ir;
  logic                     s1_valid, s1_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      p_rr    <= xa_re * xb_re;
      p_ii    <= xa_im * xb_im;
      p_ri    <= xa_re * xb_im;
      p_ir    <= xa_im * xb_re;
      s1_last <= in_last;
    end
  end

  // Stage 2: combine and drop the low bits (floor)
  logic signed [PROD_W-1:0] sum_re, sum_im;
  assign sum_re = p_rr - p_ii;
  assign sum_im = p_ri + p_ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_data <= {sum_im[PROD_W-1:DROP], sum_re[PROD_W-1:DROP]};
      out_last <= s1_last;
    end
  end

  logic unused_low;
  assign unused_low = ^{sum_re[DROP-1:0], sum_im[DROP-1:0]};

  // R8: an accepted pair reaches stage 1 on the next edge
  a_r8_stage1_fill: assert property (@(posedge clk) disable iff (rst)
    fire |=> s1_valid);
  // R8: stage 1 moves to the output when the pipe advances
  a_r8_stage2_fill: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && adv) |=> out_valid);
  // R10: a stalled stage 1 keeps its beat
  a_r10_s1_keep: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !adv) |=> (s1_valid && $stable(p_rr) && $stable(s1_last)));
  // R9: a stalled output beat is held unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !adv) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R1: reset empties the output
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: rtl/cplx_stream_mult.sv
module cplx_stream_mult
  import cmj_pkg::*;
#(
  parameter int unsigned A_W    = CMJ_A_W,
  parameter int unsigned A_LANE = CMJ_A_LANE,
  parameter int unsigned B_W    = CMJ_B_W,
  parameter int unsigned DROP   = CMJ_DROP,
  localparam int unsigned PROD_W = A_W + B_W + 1,
  localparam int unsigned OUT_W  = PROD_W - DROP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*A_LANE-1:0] a_data,
  input  logic                a_last,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [2*B_W-1:0]    b_data,
  input  logic                b_last,
  input  logic                b_valid,
  output logic                b_ready,
  output logic [2*OUT_W-1:0]  y_data,
  output logic                y_last,
  output logic                y_valid,
  input  logic                y_ready
);
  logic adv, fire;

  cmj_join u_join (
    .clk     (clk),
    .rst     (rst),
    .a_valid (a_valid),
    .b_valid (b_valid),
    .y_valid (y_valid),
    .y_ready (y_ready),
    .a_ready (a_ready),
    .b_ready (b_ready),
    .adv     (adv),
    .fire    (fire)
  );

  logic signed [A_W-1:0] a_re, a_im;
  logic signed [B_W-1:0] b_re, b_im;

  cmj_unpack #(.LANE_W(A_LANE), .COMP_W(A_W)) u_unpack_a (
    .word    (a_data),
    .comp_re (a_re),
    .comp_im (a_im)
  );

  cmj_unpack #(.LANE_W(B_W), .COMP_W(B_W)) u_unpack_b (
    .word    (b_data),
    .comp_re (b_re),
    .comp_im (b_im)
  );

  cmj_mult_core #(.A_W(A_W), .B_W(B_W), .DROP(DROP)) u_core (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .fire      (fire),
    .a_re      (a_re),
    .a_im      (a_im),
    .b_re      (b_re),
    .b_im      (b_im),
    .in_last   (a_last),
    .out_valid (y_valid),
    .out_data  (y_data),
    .out_last  (y_last)
  );

  // R7: the sinusoid end flag is accepted and dropped
  logic unused_b_last;
  assign unused_b_last = b_last;
endmodule

// File: tb/tb_cplx_stream_mult.sv
module tb_cplx_stream_mult;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] a_data = '0;
  logic        a_last = 1'b0, a_valid = 1'b0;
  logic        a_ready;
  logic [31:0] b_data = '0;
  logic        b_last = 1'b0, b_valid = 1'b0;
  logic        b_ready;
  logic [63:0] y_data;
  logic        y_last, y_valid;
  logic        y_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_stream_mult dut (
    .clk(clk), .rst(rst),
    .a_data(a_data), .a_last(a_last), .a_valid(a_valid), .a_ready(a_ready),
    .b_data(b_data), .b_last(b_last), .b_valid(b_valid), .b_ready(b_ready),
    .y_data(y_data), .y_last(y_last), .y_valid(y_valid), .y_ready(y_ready)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // Reference queues
  logic [63:0] q_data[$];
  logic        q_last[$];
  int          q_stamp[$];
  bit          q_lat[$];
  bit          lat_mode = 0;

  bit          a_hs = 0;
  bit          prev_stall = 0;
  logic [63:0] prev_data;
  logic        prev_last;

  function automatic logic [63:0] ref_prod(logic [47:0] a, logic [31:0] b);
    longint ai = longint'($signed(a[20:0]));
    longint aq = longint'($signed(a[44:24]));
    longint bi = longint'($signed(b[15:0]));
    longint bq = longint'($signed(b[31:16]));
    longint re = ai * bi - aq * bq;
    longint im = ai * bq + aq * bi;
    re = re >>> 6;
    im = im >>> 6;
    return {im[31:0], re[31:0]};
  endfunction

  function automatic logic [47:0] pack_a(int q, int i, logic [2:0] pq, logic [2:0] pi);
    logic [20:0] qq = q[20:0];
    logic [20:0] ii = i[20:0];
    return {pq, qq, pi, ii};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic monitor();
    bit adv;
    cyc++;
    if (rst) begin
      check(!y_valid, "R1", {63'd0, y_valid}, 64'd0);
      a_hs = 0;
      prev_stall = 0;
      return;
    end
    adv = !y_valid || y_ready;
    check(a_ready == (b_valid && adv), "R2 a_ready", {63'd0, a_ready}, {63'd0, b_valid && adv});
    check(b_ready == (a_valid && adv), "R2 b_ready", {63'd0, b_ready}, {63'd0, a_valid && adv});
    if (prev_stall) begin
      check(y_valid, "R9 valid held", {63'd0, y_valid}, 64'd1);
      check(y_data === prev_data, "R9 data held", y_data, prev_data);
      check(y_last === prev_last, "R9 last held", {63'd0, y_last}, {63'd0, prev_last});
    end
    if (y_valid && y_ready) begin
      if (q_data.size() == 0) begin
        check(0, "R10 unexpected beat", y_data, 64'd0);
      end else begin
        logic [63:0] ed = q_data.pop_front();
        logic        el = q_last.pop_front();
        int          es = q_stamp.pop_front();
        bit          el8 = q_lat.pop_front();
        check(y_data[31:0] === ed[31:0], "R3 real part", {32'd0, y_data[31:0]}, {32'd0, ed[31:0]});
        check(y_data[63:32] === ed[63:32], "R4 imag part", {32'd0, y_data[63:32]}, {32'd0, ed[63:32]});
        check(y_last === el, "R7 last", {63'd0, y_last}, {63'd0, el});
        if (el8) check(cyc == es + 2, "R8 latency", 64'(cyc), 64'(es + 2));
      end
    end
    a_hs = a_valid && a_ready;
    if (a_hs) begin
      q_data.push_back(ref_prod(a_data, b_data));
      q_last.push_back(a_last);
      q_stamp.push_back(cyc);
      q_lat.push_back(lat_mode);
    end
    prev_stall = y_valid && !y_ready;
    prev_data  = y_data;
    prev_last  = y_last;
  endtask

  task automatic tick();
    @(negedge clk);
    monitor();
    @(posedge clk);
    #1;
  endtask

  task automatic directed(logic [47:0] a, logic al, logic [31:0] b, logic bl);
    a_data = a; a_last = al; a_valid = 1;
    b_data = b; b_last = bl; b_valid = 1;
    y_ready = 1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    for (int k = 0; k < 4; k++) tick();
    rst = 0;
    tick();
    check(!y_valid, "R1 after reset", {63'd0, y_valid}, 64'd0);

    // Directed vectors with the output always ready: R3 R4 R5 R6 R7 R8 R11
    lat_mode = 1;
    directed(pack_a(1, 0, 3'b000, 3'b000), 1'b0, {16'sd0, 16'sd16384}, 1'b1);
    directed(pack_a(-1048576, -1048576, 3'b111, 3'b111), 1'b1, {16'h8000, 16'h8000}, 1'b0);
    directed(pack_a(1048575, 1048575, 3'b000, 3'b000), 1'b0, {16'h7fff, 16'h8000}, 1'b0);
    directed(pack_a(-1, 3, 3'b010, 3'b101), 1'b1, {16'sd1, 16'sd1}, 1'b1);   // R5 padding junk
    directed(pack_a(0, -1, 3'b111, 3'b111), 1'b0, {16'sd0, 16'sd1}, 1'b1);   // R11 -1 floors to -1
    directed(pack_a(0, -65, 3'b111, 3'b111), 1'b1, {16'sd0, 16'sd1}, 1'b0);  // R11 -65 >>> 6 = -2
    directed(pack_a(12345, -54321, 3'b000, 3'b111), 1'b0, {16'h1234, 16'hedcb}, 1'b1); // R6
    a_valid = 0; b_valid = 0;
    for (int k = 0; k < 5; k++) tick();
    lat_mode = 0;

    // Random traffic with back-pressure: R2 R9 R10
    for (int k = 0; k < 4000; k++) begin
      if (!a_valid || a_hs) begin
        a_valid = ($urandom % 4) != 0;
        a_data  = {$urandom, $urandom};
        a_last  = $urandom;
      end
      if (!b_valid || a_hs) begin
        b_valid = ($urandom % 3) != 0;
        b_data  = $urandom;
        b_last  = $urandom;
      end
      y_ready = ($urandom % 3) != 0;
      tick();
    end

    // Drain and confirm nothing is lost: R10
    a_valid = 0; b_valid = 0; y_ready = 1;
    for (int k = 0; k < 8; k++) tick();
    check(q_data.size() == 0, "R10 all beats delivered", 64'(q_data.size()), 64'd0);
    finish_run();
  end
endmodule